// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block sits at the front of a small in-order core that keeps several hardware threads alive at once. Each thread has its own program counter, a private slice of one shared register file, and a read-only register that returns the thread's own number. On every clock the scheduler offers one instruction slot to a ready thread. It rotates through the threads, so back-to-back slots go to different threads whenever more than one can run. The external decoder looks at the offered program counter and reports, in the same cycle, the kind of instruction there (plain, load or jump), a source register index and a jump target. The scheduler reads the source operand from the issuing thread's slice and moves that thread's program counter forward.

A load puts its thread to sleep. The thread takes no further slot until the memory side returns the data on the response port. That port names the thread and the destination register. The same clock edge writes the data into the slice and wakes the thread. While one thread sleeps, the others fill the slots, which hides the memory delay. If every thread is asleep, the slot is empty for that cycle.

Top module: `bsched_top`

## Requirements
- R1: While reset is held, every thread is awake with program counter 0. The first slot after reset goes to thread 0.
- R2: The slot goes to the first awake thread found by counting upward (with wrap-around) from the thread that took the previous slot. Sleeping threads are skipped.
- R3: When two or more threads are awake, a thread never takes two slots in a row. With two threads both running, their instructions interleave.
- R4: A thread that takes a slot with kind load (dec_kind = 1) shows as asleep (thr_stalled bit set) from the next cycle. It takes no slot until a response names it.
- R5: A response naming a sleeping thread clears its sleep bit on the same edge that writes the data. The thread can take a slot in the very next cycle.
- R6: When every thread is asleep, iss_valid is low. When any thread is awake, iss_valid is high.
- R7: After a slot, the issuing thread's program counter becomes dec_target for kind jump (dec_kind = 2). For any other kind it becomes pc+1. The program counters of other threads do not change, so each thread's instructions come out in its own program order.
- R8: Registers are held at address {thread, index}. iss_rs_data returns the issuing thread's own copy of register dec_rs. A response writes only the named thread's copy.
- R9: Register index 0 always reads as the issuing thread's number, zero-extended. A response that targets index 0 changes nothing.
- R10: The issue stream has no ready signal, and the consumer must take every slot that has iss_valid high. The decode inputs are sampled in the slot's own cycle. The response port has no ready signal and carries at most one response per cycle. A response naming a thread that is awake still writes its register and leaves that thread's sleep bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | output | 1 | A thread takes the slot this cycle |
| iss_tid | output | $clog2(NTHR) | Thread taking the slot |
| iss_pc | output | AW | Program counter of that thread |
| iss_rs_data | output | DW | Source operand from the thread's slice |
| dec_kind | input | 2 | Instruction kind: 0 plain, 1 load, 2 jump, 3 treated as plain |
| dec_rs | input | $clog2(NREG) | Source register index |
| dec_target | input | AW | Jump target |
| resp_valid | input | 1 | A load response is present |
| resp_tid | input | $clog2(NTHR) | Thread the response belongs to |
| resp_rd | input | $clog2(NREG) | Destination register index |
| resp_data | input | DW | Load data |
| thr_stalled | output | NTHR | Per-thread sleep bits |

## Verification
A wrong rotation pointer or a corrupted sleep bit shows on iss_tid or thr_stalled in the next cycle. The bench compares both against its own model on every clock, so it catches the fault at once. A program counter that moves on the wrong slot, or a write that lands in another thread's slice, only shows when that thread next takes a slot: as a wrong iss_pc, or as a wrong iss_rs_data when the dependent store reads the loaded register. With two threads of different load latency, each of those faults appears within a few tens of cycles.

// File: rtl/bsched_pkg.sv
`timescale 1ns/1ps
package bsched_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_JUMP  = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  // register index that reads as the thread number and ignores writes
  localparam int unsigned SELF_ID_REG = 0;
endpackage

// File: rtl/bsched_rr_pick.sv
`timescale 1ns/1ps
module bsched_rr_pick #(
  parameter  int unsigned NTHR = 4,
  localparam int unsigned TW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0] ready,
  input  logic [TW-1:0]   last,
  output logic            any,
  output logic [TW-1:0]   pick
);
  // walk offsets from farthest to nearest so the nearest ready thread wins
  always_comb begin
    any  = |ready;
    pick = last;
    for (int unsigned off = NTHR; off >= 1; off--) begin
      logic [TW-1:0] cand;
      cand = TW'((32'(last) + off) % NTHR);
      if (ready[cand]) pick = cand;
    end
  end
endmodule

// File: rtl/bsched_thread_ctx.sv
`timescale 1ns/1ps
module bsched_thread_ctx
  import bsched_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  kind_e         kind,
  input  logic [AW-1:0] target,
  input  logic          wake,
  output logic [AW-1:0] pc,
  output logic          asleep
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      asleep <= 1'b0;
    end else begin
      if (take) begin
        if (kind == KIND_JUMP) pc <= target;
        else                   pc <= pc + AW'(1);
      end
      // a load taken this cycle wins over a wake for the same thread
      if (take && kind == KIND_LOAD) asleep <= 1'b1;
      else if (wake)                 asleep <= 1'b0;
    end
  end
endmodule

// File: rtl/bsched_slice_rf.sv
`timescale 1ns/1ps
module bsched_slice_rf
  import bsched_pkg::*;
#(
  parameter  int unsigned NTHR  = 4,
  parameter  int unsigned NREG  = 8,
  parameter  int unsigned DW    = 32,
  localparam int unsigned TW    = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int unsigned RW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned DEPTH = NTHR << RW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [TW-1:0] wtid,
  input  logic [RW-1:0] wreg,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] rtid,
  input  logic [RW-1:0] rreg,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];
  logic [TW+RW-1:0] waddr, raddr;

  // thread number in the high bits, register index in the low bits
  assign waddr = {wtid, wreg};
  assign raddr = {rtid, rreg};

  always_ff @(posedge clk) begin
    if (we && wreg != RW'(SELF_ID_REG)) mem[waddr] <= wdata;
  end

  assign rdata = (rreg == RW'(SELF_ID_REG)) ? DW'(rtid) : mem[raddr];
endmodule

// File: rtl/bsched_top.sv
`timescale 1ns/1ps
module bsched_top
  import bsched_pkg::*;
#(
  parameter  int unsigned NTHR = 4,
  parameter  int unsigned NREG = 8,
  parameter  int unsigned DW   = 32,
  parameter  int unsigned AW   = 16,
  localparam int unsigned TW   = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int unsigned RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            iss_valid,
  output logic [TW-1:0]   iss_tid,
  output logic [AW-1:0]   iss_pc,
  output logic [DW-1:0]   iss_rs_data,
  input  logic [1:0]      dec_kind,
  input  logic [RW-1:0]   dec_rs,
  input  logic [AW-1:0]   dec_target,
  input  logic            resp_valid,
  input  logic [TW-1:0]   resp_tid,
  input  logic [RW-1:0]   resp_rd,
  input  logic [DW-1:0]   resp_data,
  output logic [NTHR-1:0] thr_stalled
);
  kind_e         kind;
  logic [TW-1:0] last_q;
  logic [TW-1:0] pick;
  logic          any;
  logic [AW-1:0] pc_arr [NTHR];

  assign kind = kind_e'(dec_kind);

  bsched_rr_pick #(.NTHR(NTHR)) u_pick (
    .ready (~thr_stalled),
    .last  (last_q),
    .any   (any),
    .pick  (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_q <= TW'(NTHR - 1);
    else if (any) last_q <= pick;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    bsched_thread_ctx #(.AW(AW)) u_ctx (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (any && pick == TW'(t)),
      .kind   (kind),
      .target (dec_target),
      .wake   (resp_valid && resp_tid == TW'(t)),
      .pc     (pc_arr[t]),
      .asleep (thr_stalled[t])
    );
  end

  bsched_slice_rf #(.NTHR(NTHR), .NREG(NREG), .DW(DW)) u_rf (
    .clk   (clk),
    .we    (resp_valid),
    .wtid  (resp_tid),
    .wreg  (resp_rd),
    .wdata (resp_data),
    .rtid  (pick),
    .rreg  (dec_rs),
    .rdata (iss_rs_data)
  );

  assign iss_valid = any;
  assign iss_tid   = pick;
  assign iss_pc    = pc_arr[pick];
endmodule

// File: rtl/bsched_chk.sv
`timescale 1ns/1ps
module bsched_chk
  import bsched_pkg::*;
#(
  parameter  int unsigned NTHR = 4,
  parameter  int unsigned NREG = 8,
  parameter  int unsigned DW   = 32,
  parameter  int unsigned AW   = 16,
  localparam int unsigned TW   = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int unsigned RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic [TW-1:0]   iss_tid,
  input logic [DW-1:0]   iss_rs_data,
  input logic [1:0]      dec_kind,
  input logic [RW-1:0]   dec_rs,
  input logic            resp_valid,
  input logic [TW-1:0]   resp_tid,
  input logic [NTHR-1:0] thr_stalled
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3
  switch_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && iss_valid && $past(iss_valid) && $countones(~thr_stalled) >= 2)
      |-> iss_tid != $past(iss_tid));

  // R4
  sleeper_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !thr_stalled[iss_tid]);

  // R4
  load_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && dec_kind == KIND_LOAD) |=> thr_stalled[$past(iss_tid)]);

  // R5
  resp_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && thr_stalled[resp_tid]) |=> !thr_stalled[$past(resp_tid)]);

  // R6
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&thr_stalled) |-> !iss_valid);

  // R6
  busy_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&thr_stalled) |-> iss_valid);

  // R9
  self_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && dec_rs == RW'(SELF_ID_REG)) |-> iss_rs_data == DW'(iss_tid));

  for (genvar t = 0; t < NTHR; t++) begin : g_hold
    // R4
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_stalled[t] && !(resp_valid && resp_tid == TW'(t))) |=> thr_stalled[t]);
  end
endmodule

bind bsched_top bsched_chk #(.NTHR(NTHR), .NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .iss_valid   (iss_valid),
  .iss_tid     (iss_tid),
  .iss_rs_data (iss_rs_data),
  .dec_kind    (dec_kind),
  .dec_rs      (dec_rs),
  .resp_valid  (resp_valid),
  .resp_tid    (resp_tid),
  .thr_stalled (thr_stalled)
);

// File: tb/test_bsched_top.sv
`timescale 1ns/1ps
module test_bsched_top;
  localparam int NT = 4;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid;
  logic [1:0]  iss_tid;
  logic [15:0] iss_pc;
  logic [31:0] iss_rs_data;
  logic [1:0]  dec_kind;
  logic [2:0]  dec_rs;
  logic [15:0] dec_target;
  logic        resp_valid = 1'b0;
  logic [1:0]  resp_tid = '0;
  logic [2:0]  resp_rd = '0;
  logic [31:0] resp_data = '0;
  logic [3:0]  thr_stalled;
  bit          phase2 = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bsched_top i_bsched_top (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tid(iss_tid),
    .iss_pc(iss_pc), .iss_rs_data(iss_rs_data), .dec_kind(dec_kind),
    .dec_rs(dec_rs), .dec_target(dec_target), .resp_valid(resp_valid),
    .resp_tid(resp_tid), .resp_rd(resp_rd), .resp_data(resp_data),
    .thr_stalled(thr_stalled)
  );

  // test program: threads 0/1 alternate dependent load/store, 2/3 loop and read self id
  function automatic int f_kind(int t, int pc, bit p2);
    if (p2) return 1;
    if (t < 2) return (pc == 15) ? 2 : ((pc % 2 == 0) ? 1 : 0);
    if (pc == 9) return 2;
    if (t == 2) return (pc == 5) ? 1 : 0;
    return (pc == 6) ? 1 : 0;
  endfunction
  function automatic int f_target(int t);
    return (t < 2) ? 0 : 2;
  endfunction
  function automatic int f_rs(int t, int pc, bit p2);
    if (p2) return 0;
    if (t < 2) return (pc % 2 == 1) ? ((pc >> 1) % 7) + 1 : 0;
    if (t == 2) return (pc == 7) ? 6 : 0;
    return (pc == 8) ? 7 : 0;
  endfunction
  function automatic int f_rd(int t, int pc, bit p2);
    if (p2) return 1;
    if (t < 2) return ((pc >> 1) % 7) + 1;
    return (t == 2) ? 6 : 7;
  endfunction
  function automatic int f_lat(int t, bit p2);
    if (p2) return 20;
    case (t)
      0: return 3;
      1: return 9;
      2: return 12;
      default: return 14;
    endcase
  endfunction

  assign dec_kind   = 2'(f_kind(int'(iss_tid), int'(iss_pc), phase2));
  assign dec_rs     = 3'(f_rs(int'(iss_tid), int'(iss_pc), phase2));
  assign dec_target = 16'(f_target(int'(iss_tid)));

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model state
  int m_pc [NT];
  bit m_st [NT];
  int m_last;
  int m_rf [NT][NR];
  int q_due[$], q_tid[$], q_rd[$], q_dat[$];
  int next_store [2];
  int stores [2];
  int last_store_t = -1;
  int switches = 0;
  int idle_seen = 0;
  int woken = -1;
  bit after_inject = 1'b0;

  function automatic int model_mask();
    int m = 0;
    for (int i = 0; i < NT; i++) if (m_st[i]) m |= (1 << i);
    return m;
  endfunction

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin
      m_pc[i] = 0; m_st[i] = 0;
      for (int r = 0; r < NR; r++) m_rf[i][r] = 0;
    end
    m_last = NT - 1;
    next_store[0] = 1; next_store[1] = 1;
    stores[0] = 0; stores[1] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(thr_stalled == 4'b0, "R1", thr_stalled, 0);
    chk(iss_pc == 16'd0, "R1", iss_pc, 0);
    chk(iss_tid == 2'd0, "R1", iss_tid, 0);
    rst_n = 1'b1;
    for (int n = 0; n < 320; n++) begin
      int  t;
      bit  ev;
      int  k;
      int  rs;
      int  rv_idx;
      phase2 = (n >= 200);
      #0;
      ev = 0; t = 0;
      for (int o = 1; o <= NT; o++) begin
        int c;
        c = (m_last + o) % NT;
        if (!ev && !m_st[c]) begin ev = 1; t = c; end
      end
      chk(iss_valid == ev, ev ? "R2" : "R6", iss_valid, ev);
      if (!ev) idle_seen++;
      chk(int'(thr_stalled) == model_mask(), after_inject ? "R10" : "R4",
          thr_stalled, model_mask());
      if (woken >= 0) chk(thr_stalled[woken] == 1'b0, "R5", thr_stalled[woken], 0);
      k = 0;
      if (ev) begin
        k  = f_kind(t, m_pc[t], phase2);
        rs = f_rs(t, m_pc[t], phase2);
        chk(int'(iss_tid) == t, "R2", iss_tid, t);
        chk(int'(iss_pc) == m_pc[t], "R7", iss_pc, m_pc[t]);
        if (rs == 0) chk(iss_rs_data == 32'(t), "R9", iss_rs_data, t);
        else chk(iss_rs_data == 32'(m_rf[t][rs]), "R8", iss_rs_data, m_rf[t][rs]);
        if (!phase2 && t < 2 && k == 0) begin
          // store order per thread
          chk(m_pc[t] == next_store[t], "R7", m_pc[t], next_store[t]);
          next_store[t] = (next_store[t] == 13) ? 1 : next_store[t] + 2;
          stores[t]++;
          if (last_store_t >= 0 && last_store_t != t) switches++;
          last_store_t = t;
        end
      end
      // response selection and drive
      woken = -1;
      after_inject = 1'b0;
      resp_valid = 1'b0;
      if (n == 40 || n == 41) begin
        resp_valid = 1'b1;
        resp_tid   = (n == 40) ? 2'd2 : 2'd3;
        resp_rd    = (n == 40) ? 3'd0 : 3'd5;
        resp_data  = (n == 40) ? 32'h0000dead : 32'h0000beef;
        after_inject = !m_st[int'(resp_tid)];
      end else begin
        rv_idx = -1;
        for (int i = 0; i < q_due.size(); i++)
          if (rv_idx < 0 && q_due[i] <= n) rv_idx = i;
        if (rv_idx >= 0) begin
          resp_valid = 1'b1;
          resp_tid   = 2'(q_tid[rv_idx]);
          resp_rd    = 3'(q_rd[rv_idx]);
          resp_data  = 32'(q_dat[rv_idx]);
          q_due.delete(rv_idx); q_tid.delete(rv_idx);
          q_rd.delete(rv_idx);  q_dat.delete(rv_idx);
        end
      end
      // model update for the coming edge
      if (resp_valid) begin
        int rt;
        rt = int'(resp_tid);
        if (resp_rd != 3'd0) m_rf[rt][int'(resp_rd)] = int'(resp_data);
        if (m_st[rt]) woken = rt;
        m_st[rt] = 0;
      end
      if (ev) begin
        if (k == 2) m_pc[t] = f_target(t);
        else        m_pc[t] = (m_pc[t] + 1) & 16'hffff;
        if (k == 1) begin
          m_st[t] = 1;
          q_due.push_back(n + f_lat(t, phase2));
          q_tid.push_back(t);
          q_rd.push_back(f_rd(t, m_pc[t] - 1, phase2));
          q_dat.push_back((t << 24) | ((n * 37) & 16'hffff));
        end
        m_last = t;
        if (woken == t) woken = -1;
      end
      @(negedge clk);
    end
    chk(stores[0] >= 5, "R3", stores[0], 5);
    chk(stores[1] >= 5, "R3", stores[1], 5);
    chk(switches >= 4, "R3", switches, 4);
    chk(idle_seen >= 1, "R6", idle_seen, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule